// File: doc/BRIEF.md
# Bit-Serial Bus EEPROM Protocol Engine

This block is the device-side controller of a nonvolatile memory that sits on a processor's parallel bus but carries every command, address and data bit over a single I/O line. The host runs ordinary bus cycles. A chip-enable cycle with output enable low is a read, and one with write enable low is a write that carries one bit. The engine registers each cycle when chip enable returns high. It infers the operation from the order of reads and writes and from the written bit value, not from opcodes.

The supported operations are a reset sequence, a 16-bit address load, sequential byte reads with address roll-over, and a page load into a buffer of `PAGE_BYTES` bytes. A start sequence launches a self-timed write that commits the loaded bytes to a behavioural array after `NV_CYCLES` clocks. A write-enable latch, gated by an active-low write-protect pin, guards that commit. While the write runs, any read of the I/O line returns 0.

All bus strobes are synchronised to `clk`. The bus side has no back-pressure and no handshake: the host paces every bit, and the engine answers within one cycle. This means no valid/ready interface applies.

Top module: `bsee_engine`

## Requirements
- R1: A cycle is a write when write enable was low during it. Its bit is the I/O value at whichever of write enable or chip enable rises first. A cycle with output enable low and write enable high is a read.
- R2: The sequence read, write 0, read puts the engine in the ready state and sets the write-enable latch when write protect is high. From then on, reads return 1 until an address has been loaded.
- R3: The address is 16 write cycles, most significant bit first. If any bit at or above `ADDR_W` is 1, the engine goes idle with the latch cleared: it neither reads data nor commits.
- R4: After the address, each 8 reads return one byte, MSB first. The address then increments, and the address after the top of the array is 0.
- R5: A write of 1 during a sequential read ends it. The engine goes idle, and later reads return 1.
- R6: Page load stores a byte every 8 writes at the address's low log2(`PAGE_BYTES`) bits, which wrap within the page. Byte `PAGE_BYTES`+1 overwrites the first.
- R7: After a whole-byte load, the sequence read, write 1, read starts a write when the latch is set. `NV_CYCLES` clocks later, only the bytes loaded are written into the page, and other bytes of the page keep their values.
- R8: While the write runs, reads return 0 and a reset sequence has no effect. After completion, reads in idle return 1.
- R9: Write protect low clears the latch and blocks any new commit. Write protect going low during a running write does not stop that write.
- R10: These illegal sequences send the engine to idle with the latch cleared, so no commit follows:
  - read, write, write;
  - read, write 1 during an address or a partial byte;
  - read, read, write 1 after a data load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 1 | Serial data from the host |
| io_out | output | 1 | Serial data or status to the host |
| io_oe | output | 1 | High while the host runs a read cycle |

## Verification
A running nonvolatile write can overlap two other functions. The first is write protect falling: the bench drops write protect while the write is busy and then reads the page back, expecting the new byte. The second is a complete reset sequence: the bench issues one during the busy window and expects every read in it to return 0, then expects the committed data afterwards. The bench also provokes page-offset wrap together with a byte store, by loading one byte more than a page holds.

// File: rtl/bsee_pkg.sv
package bsee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_READY, ST_ADDR, ST_AFTER, ST_READ, ST_LOAD,
    ST_LD_R, ST_LD_RR, ST_LD_RW1, ST_BRK, ST_BRK0
  } st_e;

  typedef struct packed {
    logic valid;
    logic is_wr;
    logic bit_v;
  } cyc_t;
endpackage

// File: rtl/bsee_busif.sv
module bsee_busif #(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_n,
  input  logic           oe_n,
  input  logic           we_n,
  input  logic           wp_n,
  input  logic           io_in,
  output bsee_pkg::cyc_t ev,
  output logic           rd_active,
  output logic           wp_ok
);
  localparam int NIN = 5;
  localparam logic [NIN-1:0] RSTV = 5'b10111; // wp,din,we,oe,ce

  logic [NIN-1:0] stg [SYNC_STAGES];
  logic [NIN-1:0] sy;
  logic ce_s, oe_s, we_s, din_s;
  logic ce_q, we_q, wr_seen, wr_bit, rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= RSTV;
    end else begin
      stg[0] <= {wp_n, io_in, we_n, oe_n, ce_n};
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sy    = stg[SYNC_STAGES-1];
  assign ce_s  = sy[0];
  assign oe_s  = sy[1];
  assign we_s  = sy[2];
  assign din_s = sy[3];
  assign wp_ok = sy[4];
  assign rd_active = !ce_s && !oe_s && we_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1; we_q <= 1'b1;
      wr_seen <= 1'b0; wr_bit <= 1'b0; rd_seen <= 1'b0;
      ev <= '0;
    end else begin
      ce_q <= ce_s;
      we_q <= we_s;
      ev   <= '0;
      if (!ce_s) begin
        if (!we_q && we_s && !wr_seen) begin
          wr_seen <= 1'b1;
          wr_bit  <= din_s;
        end
        if (!oe_s) rd_seen <= 1'b1;
      end
      if (ce_s && !ce_q) begin
        wr_seen <= 1'b0;
        rd_seen <= 1'b0;
        if (!we_s || !we_q)  ev <= '{valid: 1'b1, is_wr: 1'b1, bit_v: din_s};
        else if (wr_seen)    ev <= '{valid: 1'b1, is_wr: 1'b1, bit_v: wr_bit};
        else if (rd_seen)    ev <= '{valid: 1'b1, is_wr: 1'b0, bit_v: 1'b0};
      end
    end
  end

  // R1: a cycle ends only once chip enable has gone low again
  a_r1_spaced_events: assert property (@(posedge clk) disable iff (!rst_n)
    ev.valid |=> !ev.valid);
endmodule

// File: rtl/bsee_ctrl.sv
module bsee_ctrl
  import bsee_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int NV_CYCLES  = 300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cyc_t                     ev,
  input  logic                     rd_active,
  input  logic                     wp_ok,
  input  logic [7:0]               rd_byte,
  output logic                     wr_stb,
  output logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
  output logic [7:0]               wr_data,
  output logic                     buf_clr,
  output logic                     commit,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     io_out,
  output logic                     io_oe
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [15:0] LO_MASK = 16'((32'd1 << ADDR_W) - 1);

  st_e st;
  logic [ADDR_W-1:0] addr;
  logic [14:0] ashift;
  logic [3:0]  acnt;
  logic [2:0]  bcnt;
  logic [6:0]  dsh;
  logic h1_rd, h1_w0, h2_rd, latch, busy;
  logic [CNT_W-1:0] timer;
  logic is_rd, w0, w1, rst_seq;
  logic [15:0] addr_new;

  assign is_rd    = ev.valid && !ev.is_wr;
  assign w0       = ev.valid && ev.is_wr && !ev.bit_v;
  assign w1       = ev.valid && ev.is_wr && ev.bit_v;
  assign rst_seq  = is_rd && h1_w0 && h2_rd;
  assign addr_new = {ashift, ev.bit_v};
  assign commit   = busy && (timer == '0);
  assign page_base = addr[ADDR_W-1:PG_W];
  assign rd_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; addr <= '0; ashift <= '0; acnt <= '0; bcnt <= '0;
      dsh <= '0; h1_rd <= 1'b0; h1_w0 <= 1'b0; h2_rd <= 1'b0;
      latch <= 1'b0; busy <= 1'b0; timer <= '0;
      wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0; buf_clr <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      buf_clr <= 1'b0;
      if (ev.valid) begin
        h2_rd <= h1_rd;
        h1_rd <= is_rd;
        h1_w0 <= w0;
      end
      if (busy) begin
        if (timer == '0) begin
          busy  <= 1'b0;
          latch <= 1'b0;
        end else timer <= timer - 1'b1;
      end else if (ev.valid) begin
        if (rst_seq) begin
          st <= ST_READY; latch <= wp_ok; acnt <= '0; bcnt <= '0; buf_clr <= 1'b1;
        end else begin
          unique case (st)
            ST_READY: if (ev.is_wr) begin
              ashift <= addr_new[14:0]; acnt <= 4'd1; st <= ST_ADDR;
            end
            ST_ADDR: if (ev.is_wr) begin
              ashift <= addr_new[14:0];
              acnt   <= acnt + 1'b1;
              if (acnt == 4'd15) begin
                if ((addr_new & ~LO_MASK) == '0) begin
                  addr <= addr_new[ADDR_W-1:0]; bcnt <= '0; st <= ST_AFTER;
                end else begin
                  st <= ST_IDLE; latch <= 1'b0;
                end
              end
            end else st <= ST_BRK;
            ST_AFTER, ST_READ: if (is_rd) begin
              bcnt <= bcnt + 1'b1;
              if (bcnt == 3'd7) addr <= addr + 1'b1;
              st <= ST_READ;
            end else if (st == ST_AFTER) begin
              dsh <= {dsh[5:0], ev.bit_v}; bcnt <= 3'd1; st <= ST_LOAD;
            end else if (ev.bit_v) begin
              st <= ST_IDLE; latch <= 1'b0;
            end else st <= ST_BRK0;
            ST_LOAD: if (ev.is_wr) begin
              dsh  <= {dsh[5:0], ev.bit_v};
              bcnt <= bcnt + 1'b1;
              if (bcnt == 3'd7) begin
                wr_stb  <= 1'b1;
                wr_idx  <= addr[PG_W-1:0];
                wr_data <= {dsh, ev.bit_v};
                addr[PG_W-1:0] <= addr[PG_W-1:0] + 1'b1;
              end
            end else st <= (bcnt == '0) ? ST_LD_R : ST_BRK;
            ST_LD_R:  st <= w1 ? ST_LD_RW1 : (w0 ? ST_BRK0 : ST_LD_RR);
            ST_LD_RR: if (w1) begin
              st <= ST_IDLE; latch <= 1'b0;
            end else if (w0) st <= ST_BRK0;
            ST_LD_RW1: begin
              st <= ST_IDLE;
              if (is_rd) begin
                if (latch) begin
                  busy <= 1'b1; timer <= CNT_W'(NV_CYCLES - 1);
                end
              end else latch <= 1'b0;
            end
            ST_BRK: if (w1) begin
              st <= ST_IDLE; latch <= 1'b0;
            end else if (w0) st <= ST_BRK0;
            ST_BRK0: begin
              st <= ST_IDLE;
              if (ev.is_wr) latch <= 1'b0;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
      if (!wp_ok) latch <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_out <= 1'b1;
      io_oe  <= 1'b0;
    end else begin
      io_oe  <= rd_active;
      io_out <= busy ? 1'b0
              : ((st == ST_AFTER || st == ST_READ) ? rd_byte[3'd7 - bcnt] : 1'b1);
    end
  end

  // R8: status low while busy
  a_r8_busy_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_active) |=> !io_out);
  // R9: write protect low empties the latch
  a_r9_wp_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_ok |=> !latch);
  // R2: ready state reads high
  a_r2_ready_reads_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READY && rd_active) |=> io_out);
  // R7: a write only launches with the latch set
  a_r7_launch_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(latch));
endmodule

// File: rtl/bsee_store.sv
module bsee_store #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_stb,
  input  logic [$clog2(PAGE_BYTES)-1:0]   wr_idx,
  input  logic [7:0]                      wr_data,
  input  logic                            buf_clr,
  input  logic                            commit,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [7:0]                      rd_byte
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pval <= '0;
    else if (buf_clr || commit) pval <= '0;
    else if (wr_stb) pval[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_stb) pbuf[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int p = 0; p < PAGE_BYTES; p++) begin
        if (pval[p]) mem[{page_base, PG_W'(p)}] <= pbuf[p];
      end
    end
  end

  assign rd_byte = mem[rd_addr];

  // R7: no byte enters the buffer while it is being committed
  a_r7_no_store_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wr_stb);
endmodule

// File: rtl/bsee_engine.sv
module bsee_engine #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int NV_CYCLES   = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic wp_n,
  input  logic io_in,
  output logic io_out,
  output logic io_oe
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  bsee_pkg::cyc_t ev;
  logic rd_active, wp_ok, wr_stb, buf_clr, commit;
  logic [PG_W-1:0] wr_idx;
  logic [7:0] wr_data, rd_byte;
  logic [ADDR_W-PG_W-1:0] page_base;
  logic [ADDR_W-1:0] rd_addr;

  bsee_busif #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp_n(wp_n), .io_in(io_in), .ev(ev), .rd_active(rd_active), .wp_ok(wp_ok));

  bsee_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .NV_CYCLES(NV_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd_active(rd_active), .wp_ok(wp_ok),
    .rd_byte(rd_byte), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .buf_clr(buf_clr), .commit(commit), .page_base(page_base),
    .rd_addr(rd_addr), .io_out(io_out), .io_oe(io_oe));

  bsee_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .buf_clr(buf_clr), .commit(commit),
    .page_base(page_base), .rd_addr(rd_addr), .rd_byte(rd_byte));
endmodule

// File: tb/bsee_engine_tb_top.sv
module bsee_engine_tb_top;
  localparam int NV = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1, io_in = 1'b0;
  logic io_out, io_oe;
  int n_cmp = 0;
  int n_bad = 0;
  logic last_oe;

  always #2 clk = ~clk;

  bsee_engine #(.ADDR_W(11), .PAGE_BYTES(32), .NV_CYCLES(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_wr(input logic b, input bit we_first);
    @(negedge clk); io_in = b; ce_n = 1'b0;
    clk_n(3);
    @(negedge clk); we_n = 1'b0;
    clk_n(4);
    if (we_first) begin
      @(negedge clk); we_n = 1'b1;
      clk_n(4);
      @(negedge clk); io_in = ~b; ce_n = 1'b1;
    end else begin
      @(negedge clk); ce_n = 1'b1;
      clk_n(4);
      @(negedge clk); we_n = 1'b1;
    end
    clk_n(4);
  endtask

  task automatic bus_rd(output logic b);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    clk_n(6);
    @(negedge clk); b = io_out; last_oe = io_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    clk_n(4);
  endtask

  task automatic reset_seq();
    logic d;
    bus_rd(d); bus_wr(1'b0, 1'b0); bus_rd(d);
  endtask

  task automatic send_addr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) bus_wr(a[i], i[0]);
  endtask

  task automatic load_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_wr(v[i], i[0]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      bus_rd(d); v[i] = d;
    end
  endtask

  task automatic start_nv();
    logic d;
    bus_rd(d); bus_wr(1'b1, 1'b0); bus_rd(d);
  endtask

  task automatic wait_nv();
    clk_n(NV + 20);
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v);
    reset_seq(); send_addr(a); load_byte(v); start_nv(); wait_nv();
  endtask

  task automatic rb1(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reset_seq(); send_addr(a); read_byte(v);
    chk(req, v, exp);
  endtask

  task automatic t_reset_state();
    logic d;
    chk("R8 io_oe after reset", io_oe, 0);
    bus_rd(d);
    chk("R8 idle status", d, 1);
    chk("R1 read cycle drives io_oe", last_oe, 1);
  endtask

  task automatic t_ready();
    logic d;
    reset_seq();
    bus_rd(d); chk("R2 ready read 1", d, 1);
    bus_rd(d); chk("R2 ready read 2", d, 1);
  endtask

  task automatic t_page();
    logic d;
    logic [7:0] v;
    reset_seq(); send_addr(16'h0040);
    load_byte(8'hA5); load_byte(8'h3C); load_byte(8'h81);
    start_nv();
    bus_rd(d); chk("R8 busy status low", d, 0);
    wait_nv();
    bus_rd(d); chk("R8 status high after write", d, 1);
    reset_seq(); send_addr(16'h0040);
    read_byte(v); chk("R7 R1 byte 0x40", v, 8'hA5);
    read_byte(v); chk("R4 sequential 0x41", v, 8'h3C);
    read_byte(v); chk("R4 sequential 0x42", v, 8'h81);
  endtask

  task automatic t_roll();
    logic [7:0] v;
    write1(16'h07FF, 8'h5A);
    write1(16'h0000, 8'hC3);
    reset_seq(); send_addr(16'h07FF);
    read_byte(v); chk("R4 top byte", v, 8'h5A);
    read_byte(v); chk("R4 rollover to 0", v, 8'hC3);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    reset_seq(); send_addr(16'h0100);
    for (int i = 0; i < 33; i++) load_byte((i == 32) ? 8'hEE : 8'(i + 1));
    start_nv(); wait_nv();
    reset_seq(); send_addr(16'h0100);
    read_byte(v); chk("R6 wrapped overwrite", v, 8'hEE);
    read_byte(v); chk("R6 second byte kept", v, 8'h02);
    rb1("R6 last page byte", 16'h011F, 8'h20);
  endtask

  task automatic t_end_read();
    logic d;
    logic [7:0] v;
    reset_seq(); send_addr(16'h0040);
    read_byte(v);
    bus_wr(1'b1, 1'b0);
    bus_rd(d); chk("R5 idle after write 1", d, 1);
    bus_rd(d); chk("R5 stays idle", d, 1);
  endtask

  task automatic t_illegal();
    logic d;
    write1(16'h0200, 8'h77);
    reset_seq(); send_addr(16'h0200); load_byte(8'h11);
    bus_rd(d); bus_wr(1'b1, 1'b0); bus_wr(1'b1, 1'b0);
    start_nv();
    bus_rd(d); chk("R10 read-write-write no busy", d, 1);
    rb1("R10 read-write-write no commit", 16'h0200, 8'h77);
    reset_seq(); send_addr(16'h0200); load_byte(8'h22);
    bus_rd(d); bus_rd(d); bus_wr(1'b1, 1'b0); bus_rd(d);
    bus_rd(d); chk("R10 read-read-write1 no busy", d, 1);
    rb1("R10 read-read-write1 no commit", 16'h0200, 8'h77);
    reset_seq(); send_addr(16'h0200);
    for (int i = 0; i < 4; i++) bus_wr(1'b0, 1'b0);
    start_nv();
    bus_rd(d); chk("R10 partial byte no busy", d, 1);
    rb1("R10 partial byte no commit", 16'h0200, 8'h77);
  endtask

  task automatic t_addr_range();
    logic d;
    reset_seq(); send_addr(16'h8040);
    bus_rd(d); chk("R3 bad address reads 1", d, 1);
    reset_seq(); send_addr(16'h8040); load_byte(8'h99); start_nv();
    bus_rd(d); chk("R3 bad address no busy", d, 1);
    rb1("R3 array unchanged", 16'h0040, 8'hA5);
  endtask

  task automatic t_wp();
    logic d;
    wp_n = 1'b0; clk_n(8);
    reset_seq(); send_addr(16'h0041); load_byte(8'h00); start_nv();
    bus_rd(d); chk("R9 protected no busy", d, 1);
    rb1("R9 protected no commit", 16'h0041, 8'h3C);
    wp_n = 1'b1; clk_n(8);
    reset_seq(); send_addr(16'h0041); load_byte(8'h55); start_nv();
    @(negedge clk); wp_n = 1'b0;
    wait_nv();
    @(negedge clk); wp_n = 1'b1; clk_n(8);
    rb1("R9 write survives wp low", 16'h0041, 8'h55);
    rb1("R7 unloaded byte kept", 16'h0040, 8'hA5);
  endtask

  task automatic t_busy_reset();
    logic d;
    reset_seq(); send_addr(16'h0042); load_byte(8'h66); start_nv();
    bus_rd(d); chk("R8 busy before reset", d, 0);
    bus_wr(1'b0, 1'b0);
    bus_rd(d); chk("R8 reset ignored while busy", d, 0);
    bus_rd(d); chk("R8 still busy", d, 0);
    wait_nv();
    bus_rd(d); chk("R8 done status", d, 1);
    rb1("R8 commit intact", 16'h0042, 8'h66);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clk_n(5);
    @(negedge clk); rst_n = 1'b1;
    clk_n(5);
    t_reset_state();
    t_ready();
    t_page();
    t_roll();
    t_wrap();
    t_end_read();
    t_illegal();
    t_addr_range();
    t_wp();
    t_busy_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule